// File: doc/BRIEF.md
# Indirect Coefficient RAM Access Port

This block gives a host bus access to a wide coefficient array through two narrow registers. One is a staging register for data and the other is an address/command register. The host can reach the array only while a hold input is high. While hold is high the filter datapath has no access. When hold drops, the array goes back to the datapath, which reads whole 48-bit words through its own port.

Each array word holds several fields:
- a 20-bit I coefficient;
- a 20-bit Q coefficient;
- a 4-bit shift for the I coefficient;
- a 4-bit shift for the Q coefficient.

Three 16-bit writes fill the staging slots. A write to the command register with the read flag clear then stores the staged word at the addressed location. A command write with the read flag set fetches a word. Each later read strobe returns one 16-bit slice of the fetched word, chosen by the slice code of that command. A command write that follows the previous accepted command by fewer than four cycles is dropped. While such a write would be dropped, busy is shown.

Top module: `coef_ram_port`

## Requirements
- R1: While `hold_i` is low, host writes to either register and host read strobes have no effect. `rvalid_o` stays 0, `rdata_o` keeps its value, and the array contents are not changed.
- R2: While `hold_i` is high, data writes (`sel_i`=0) fill three slots in turn, then wrap:
  - first slot: the packed word with nibbles {I[3:0], I shift, Q[3:0], Q shift}, most significant nibble first;
  - second slot: Q[19:4];
  - third slot: I[19:4].
  The slot pointer returns to the first slot after a store, and whenever `hold_i` is low.
- R3: The command word (`sel_i`=1) has three fields. Bit 15 is the read flag. Bits 9:8 are the slice code. Bits 5:0 are the array location.
- R4: An accepted command with bit 15 = 0 and slice code 01 writes {I[19:4], Q[19:4], packed} (bits 47:32, 31:16, 15:0) to the location. With bit 15 = 0, any other slice code writes nothing and leaves the slot pointer as it was.
- R5: An accepted command with bit 15 = 1 fetches the location. Each later read strobe (`rd_en_i` with `hold_i` high) puts a slice on `rdata_o` one cycle later, with `rvalid_o` high for that one cycle. The slice is chosen by the code of that command:
  - 01: I[19:4];
  - 10: Q[19:4];
  - 11: the packed word;
  - 00: zero.
- R6: After an accepted command, `busy_o` is high for the next three cycles. Command writes made while `busy_o` is high are ignored.
- R7: While `hold_i` is low, `dp_rd_i` reads `dp_addr_i`, and `dp_coef_o` shows that word one cycle later. `dp_coef_o` always holds the word last read from the array by either side, and is stable otherwise.
- R8: After reset:
  - `busy_o`, `rvalid_o`, `rdata_o` and `dp_coef_o` are 0;
  - the slot pointer is at the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Host owns the array while high |
| wr_en_i | input | 1 | Host write strobe |
| sel_i | input | 1 | 0 selects the data staging register, 1 selects the command register |
| wdata_i | input | 16 | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rdata_o | output | 16 | Selected slice of the fetched word |
| rvalid_o | output | 1 | `rdata_o` was updated by the last strobe |
| busy_o | output | 1 | A command write now would be ignored |
| dp_addr_i | input | 6 | Datapath read location |
| dp_rd_i | input | 1 | Datapath read strobe |
| dp_coef_o | output | 48 | Word last read from the array |

## Verification
The hardest cases to reach from the ports are commands dropped inside the busy window, and slot pointers that were reset part-way through staging. Neither case changes an output directly. The stimulus therefore first stores a known word. It then issues a store to the same location within the window, and separately drops hold after a single staged write. Later fetches and datapath reads expose the array contents, and a behavioural model checks the outputs on every cycle.

// File: rtl/coef_ram_pkg.sv
package coef_ram_pkg;
  typedef enum logic [1:0] {
    SL_NONE = 2'b00,
    SL_IHI  = 2'b01,
    SL_QHI  = 2'b10,
    SL_PACK = 2'b11
  } slice_e;

  localparam int unsigned RD_FLAG_BIT = 15;
  localparam int unsigned SLICE_LSB   = 8;
  localparam int unsigned NUM_SLOTS   = 3;
endpackage

// File: rtl/coef_stage.sv
module coef_stage
  import coef_ram_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hold_i,
  input  logic                    wr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    clr_i,
  output logic [NUM_SLOTS*DW-1:0] word_o
);
  localparam int unsigned PW = $clog2(NUM_SLOTS);

  logic [DW-1:0] slot_q [NUM_SLOTS];
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (!hold_i || clr_i) begin
      ptr_q <= '0;
    end else if (wr_i) begin
      ptr_q <= (ptr_q == PW'(NUM_SLOTS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[g] <= '0;
      else if (hold_i && wr_i && ptr_q == PW'(g))     slot_q[g] <= wdata_i;
    end
    assign word_o[g*DW +: DW] = slot_q[g];
  end

  // R2: the last slot wraps back to the first
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && wr_i && !clr_i && ptr_q == PW'(NUM_SLOTS - 1)) |=> (ptr_q == '0));
endmodule

// File: rtl/coef_cmd.sv
module coef_cmd
  import coef_ram_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 6,
  parameter int unsigned GAP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic          fetch_o,
  output logic [AW-1:0] addr_o,
  output slice_e        slice_o
);
  localparam int unsigned CW = $clog2(GAP);

  logic [CW-1:0] gap_q;
  slice_e        slice_q;
  slice_e        slice_w;
  logic          accept;

  assign slice_w  = slice_e'(wdata_i[SLICE_LSB +: 2]);
  assign accept   = hold_i && wr_i && (gap_q == '0);
  assign commit_o = accept && !wdata_i[RD_FLAG_BIT] && (slice_w == SL_IHI);
  assign fetch_o  = accept && wdata_i[RD_FLAG_BIT];
  assign addr_o   = wdata_i[AW-1:0];
  assign busy_o   = (gap_q != '0);
  assign slice_o  = slice_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      slice_q <= SL_NONE;
    end else begin
      if (accept)            gap_q <= CW'(GAP - 1);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
      if (fetch_o)           slice_q <= slice_w;
    end
  end

  a_r6_busy_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  a_r6_one_per_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || fetch_o) |=> !(commit_o || fetch_o));
endmodule

// File: rtl/coef_mem.sv
module coef_mem #(
  parameter int unsigned AW = 6,
  parameter int unsigned WW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_sel_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_we_i,
  input  logic          host_re_i,
  input  logic [WW-1:0] host_wdata_i,
  input  logic [AW-1:0] dp_addr_i,
  input  logic          dp_re_i,
  output logic [WW-1:0] q_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [WW-1:0] mem_q [DEPTH];
  logic [AW-1:0] addr;
  logic          re;

  // single port: the owner drives the one address
  assign addr = host_sel_i ? host_addr_i : dp_addr_i;
  assign re   = host_sel_i ? host_re_i : dp_re_i;

  always_ff @(posedge clk_i) begin
    if (host_sel_i && host_we_i) mem_q[addr] <= host_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= '0;
    else if (re)  q_o <= mem_q[addr];
  end

  a_r1_we_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |-> host_sel_i);
endmodule

// File: rtl/coef_ram_port.sv
module coef_ram_port
  import coef_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned GAP    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hold_i,
  input  logic                  wr_en_i,
  input  logic                  sel_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  rd_en_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  rvalid_o,
  output logic                  busy_o,
  input  logic [ADDR_W-1:0]     dp_addr_i,
  input  logic                  dp_rd_i,
  output logic [3*DATA_W-1:0]   dp_coef_o
);
  localparam int unsigned WW = NUM_SLOTS * DATA_W;

  logic          commit, fetch;
  logic [ADDR_W-1:0] cmd_addr;
  slice_e        slice;
  logic [WW-1:0] staged, q;
  logic [DATA_W-1:0] pick;

  coef_stage #(.DW(DATA_W)) u_stage (
    .clk_i, .rst_ni, .hold_i,
    .wr_i   (wr_en_i && !sel_i),
    .wdata_i,
    .clr_i  (commit),
    .word_o (staged)
  );

  coef_cmd #(.DW(DATA_W), .AW(ADDR_W), .GAP(GAP)) u_cmd (
    .clk_i, .rst_ni, .hold_i,
    .wr_i     (wr_en_i && sel_i),
    .wdata_i,
    .busy_o,
    .commit_o (commit),
    .fetch_o  (fetch),
    .addr_o   (cmd_addr),
    .slice_o  (slice)
  );

  coef_mem #(.AW(ADDR_W), .WW(WW)) u_mem (
    .clk_i, .rst_ni,
    .host_sel_i   (hold_i),
    .host_addr_i  (cmd_addr),
    .host_we_i    (commit),
    .host_re_i    (fetch),
    .host_wdata_i (staged),
    .dp_addr_i,
    .dp_re_i      (dp_rd_i),
    .q_o          (q)
  );

  always_comb begin
    unique case (slice)
      SL_IHI:  pick = q[2*DATA_W +: DATA_W];
      SL_QHI:  pick = q[DATA_W +: DATA_W];
      SL_PACK: pick = q[0 +: DATA_W];
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= hold_i && rd_en_i;
      if (hold_i && rd_en_i) rdata_o <= pick;
    end
  end

  assign dp_coef_o = q;

  a_r1_quiet_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> (!rvalid_o && $stable(rdata_o)));
  a_r7_dp_stable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !fetch) |=> $stable(dp_coef_o));
endmodule

// File: tb/coef_ram_port_bench.sv
module coef_ram_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b0, wr_en = 1'b0, sel = 1'b0, rd_en = 1'b0, dp_rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [5:0]  dp_addr = '0;
  logic [15:0] rdata_o;
  logic        rvalid_o, busy_o;
  logic [47:0] dp_coef_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R8 reset";

  always #2 clk = ~clk;

  coef_ram_port u_coef_ram_port (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .wr_en_i(wr_en), .sel_i(sel),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o, .rvalid_o, .busy_o,
    .dp_addr_i(dp_addr), .dp_rd_i(dp_rd), .dp_coef_o
  );

  // behavioural reference
  logic [15:0] m_slot [3];
  int          m_ptr, m_gap;
  logic [47:0] m_mem [64];
  logic [47:0] m_q;
  logic [1:0]  m_slice;
  logic [15:0] m_rdata;
  bit          m_rvalid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_gap = 0; m_q = '0; m_slice = 0; m_rdata = '0; m_rvalid = 0;
      foreach (m_slot[i]) m_slot[i] = '0;
    end else begin
      bit acc;
      m_rvalid = hold && rd_en;
      if (m_rvalid) begin
        case (m_slice)
          2'd1: m_rdata = m_q[47:32];
          2'd2: m_rdata = m_q[31:16];
          2'd3: m_rdata = m_q[15:0];
          default: m_rdata = 16'h0;
        endcase
      end
      if (!hold) begin
        m_ptr = 0;
        if (dp_rd) m_q = m_mem[dp_addr];
        if (m_gap > 0) m_gap--;
      end else begin
        if (wr_en && !sel) begin
          m_slot[m_ptr] = wdata;
          m_ptr = (m_ptr + 1) % 3;
        end
        acc = wr_en && sel && (m_gap == 0);
        if (acc) m_gap = 3; else if (m_gap > 0) m_gap--;
        if (acc && !wdata[15] && wdata[9:8] == 2'b01) begin
          m_mem[wdata[5:0]] = {m_slot[2], m_slot[1], m_slot[0]};
          m_ptr = 0;
        end
        if (acc && wdata[15]) begin
          m_q = m_mem[wdata[5:0]];
          m_slice = wdata[9:8];
        end
      end
    end
  end

  task automatic chk(input string what, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R5 rvalid_o", 48'(rvalid_o), 48'(m_rvalid));
    chk("R5 rdata_o", 48'(rdata_o), 48'(m_rdata));
    chk("R6 busy_o", 48'(busy_o), 48'(m_gap != 0));
    chk("R7 dp_coef_o", dp_coef_o, m_q);
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic dwr(input logic [15:0] v);
    wr_en = 1; sel = 0; wdata = v; tick(); wr_en = 0;
  endtask
  task automatic cwr(input logic [15:0] v);
    wr_en = 1; sel = 1; wdata = v; tick(); wr_en = 0;
  endtask
  task automatic idle(input int n); repeat (n) tick(); endtask
  task automatic rstb(); rd_en = 1; tick(); rd_en = 0; endtask
  task automatic store(input logic [5:0] a, input logic [19:0] ic, input logic [19:0] qc,
                       input logic [3:0] is, input logic [3:0] qs);
    dwr({ic[3:0], is, qc[3:0], qs});
    dwr(qc[19:4]);
    dwr(ic[19:4]);
    cwr({6'b0, 2'b01, 2'b0, a});
    idle(3);
  endtask
  task automatic fetch_all(input logic [5:0] a);
    for (int s = 0; s < 4; s++) begin
      cwr({1'b1, 5'b0, 2'(s), 2'b0, a});
      idle(3);
      rstb();
    end
    idle(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);

    hold = 1;
    phase = "R2 R4 store";
    store(6'd5, 20'hABCDE, 20'h12345, 4'h7, 4'h9);
    phase = "R3 R5 slices";
    fetch_all(6'd5);

    phase = "R2 R4 store sweep";
    for (int i = 0; i < 12; i++)
      store(6'(i * 5 + 1), 20'(i * 32'h1357B), 20'(32'hFFFFF - i * 32'h2468), 4'(i), 4'(15 - i));
    for (int i = 0; i < 12; i += 3) fetch_all(6'(i * 5 + 1));

    phase = "R6 busy drop";
    store(6'd9, 20'h11111, 20'h22222, 4'h3, 4'h4);
    dwr(16'hDEAD); dwr(16'hBEEF); dwr(16'hF00D);
    cwr({6'b0, 2'b01, 2'b0, 6'd9});
    cwr({6'b0, 2'b01, 2'b0, 6'd9});
    cwr({1'b1, 5'b0, 2'b11, 2'b0, 6'd9});
    cwr({1'b1, 5'b0, 2'b01, 2'b0, 6'd9});
    idle(1);
    rstb(); idle(2);
    fetch_all(6'd9);

    phase = "R4 other slice code no write";
    dwr(16'h0101); dwr(16'h0202); dwr(16'h0303);
    cwr({6'b0, 2'b10, 2'b0, 6'd5});
    idle(3);
    fetch_all(6'd5);
    cwr({6'b0, 2'b01, 2'b0, 6'd20});
    idle(3);
    fetch_all(6'd20);

    phase = "R1 no hold";
    hold = 0;
    idle(1);
    dwr(16'h5555); dwr(16'h6666); dwr(16'h7777);
    cwr({6'b0, 2'b01, 2'b0, 6'd5});
    rstb();
    cwr({1'b1, 5'b0, 2'b01, 2'b0, 6'd5});
    rstb(); idle(2);

    phase = "R7 datapath read";
    for (int i = 0; i < 12; i++) begin
      dp_addr = 6'(i * 5 + 1); dp_rd = 1; tick();
    end
    dp_rd = 0; dp_addr = 6'd5; idle(2);
    dp_addr = 6'd9; dp_rd = 1; tick(); dp_rd = 0; idle(2);

    phase = "R2 pointer reset on hold low";
    hold = 1; dwr(16'h9999);
    hold = 0; idle(1);
    hold = 1;
    store(6'd30, 20'h0F0F0, 20'hA5A5A, 4'hC, 4'h2);
    fetch_all(6'd30);
    hold = 0; dp_addr = 6'd30; dp_rd = 1; tick(); dp_rd = 0; idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule